// File: doc/BRIEF.md
# Dual-Mode Gain Word Loader

This block produces a 4-bit gain control word for a step-gain amplifier. The word can be loaded in two ways, and a mode pin picks one of them. In parallel loading, the four data pins feed a holding register. An enable strobe makes that register follow the pins or freeze it. In serial loading, two of the data pins act as a bit line and a bit clock. They fill a four-stage shift register, and the word moves into the holding register only when the strobe rises. The signal path therefore sees a new gain only at a moment the user chooses.

All pins are treated as asynchronous. One system clock samples them through two-flop synchronizers, and the design finds the strobe and bit-clock edges by comparing each sample with the one before. A small state machine remembers the mode and strobe level sampled in the previous cycle:

- `ST_PAR_HOLD`: parallel mode, strobe low.
- `ST_PAR_OPEN`: parallel mode, strobe high.
- `ST_SER_ARMED`: serial mode, strobe low.
- `ST_SER_LOCKED`: serial mode, strobe high.

Every state can move to any other state. The next state is the pair (sampled mode, sampled strobe). A move from `ST_PAR_HOLD` or `ST_SER_ARMED` into `ST_SER_LOCKED` is a strobe rise in serial mode, and that move is the transfer. Any move while the sampled strobe is high in parallel mode loads the pins. Staying in `ST_SER_ARMED` while a bit-clock rise is seen shifts one bit. A synchronous reset returns to `ST_PAR_HOLD` and clears both registers.

Top module: `gain_word_if`

## Requirements
- R1: Reset clears the gain word and the shift register to the minimum-gain code 4'b0000. With all pins held low, the gain stays 4'b0000.
- R2: `mode_sel` low selects parallel loading and high selects serial loading. In serial mode, changes on `data_in` never reach `gain_q` directly.
- R3: In parallel mode, while the sampled strobe is high, `gain_q` follows `data_in`.
- R4: In parallel mode, while the sampled strobe is low, `gain_q` keeps the word sampled in the last strobe-high cycle, whatever `data_in` does.
- R5: In serial mode, `data_in[0]` is the serial bit and `data_in[1]` is the bit clock. Each sampled rising edge of the bit clock, seen while the strobe is low, shifts the bit into bit 0 and moves older bits toward bit 3. The first bit sent therefore ends up as the MSB after four edges.
- R6: In serial mode, `gain_q` changes only on a sampled rising edge of the strobe, and it then takes the shift register contents.
- R7: While the strobe is high in serial mode, bit-clock edges are ignored and the shift register keeps its contents.
- R8: In parallel mode, edges on `data_in[1]` do not shift the shift register.
- R9: When a strobe rise and a bit-clock rise are sampled in the same cycle in serial mode, the transfer happens and the bit is not shifted.
- R10: Every pin goes through a two-flop synchronizer. A pin change made before clock edge n takes effect on `gain_q` at edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Loading mode select: 0 parallel, 1 serial |
| strobe_in | input | 1 | Enable strobe (asynchronous) |
| data_in | input | WORD_W | Parallel word. In serial mode, bit 0 is the serial bit and bit 1 is the bit clock |
| gain_q | output | WORD_W | Gain control word |

## Verification
In serial mode, two functions can fall in the same sampled cycle: the strobe-rise transfer and a bit-clock shift. The bench drives the rising strobe and the rising bit clock on the same clock cycle, with the serial bit set to one. It first checks that the gain takes the old shift contents. It then lowers the strobe and raises it again without a new bit-clock edge, and checks that the shift register did not absorb the colliding bit. A behavioural reference model with a history queue predicts `gain_q` on every cycle, so any extra or missing shift in the collision shows up at once.

// File: rtl/gwi_pkg.sv
package gwi_pkg;

    // State remembers the mode and strobe level sampled in the previous cycle
    typedef enum logic [1:0] {
        ST_PAR_HOLD   = 2'b00,
        ST_PAR_OPEN   = 2'b01,
        ST_SER_ARMED  = 2'b10,
        ST_SER_LOCKED = 2'b11
    } gwi_state_e;

    // Pin roles inside the data bus in serial mode
    localparam int SDATA_IDX = 0;
    localparam int SCLK_IDX  = 1;

endpackage

// File: rtl/gwi_sync.sv
module gwi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gwi_rise.sv
module gwi_rise (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);

    logic lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b0;
        end else begin
            lvl_prev <= lvl;
        end
    end

    assign rise = lvl & ~lvl_prev;

endmodule

// File: rtl/gwi_ctrl.sv
module gwi_ctrl
    import gwi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_s,
    input  logic str_s,
    input  logic sclk_rise,
    output logic load_par,
    output logic load_ser,
    output logic shift_en
);

    gwi_state_e state_q;
    gwi_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PAR_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: the sampled mode/strobe pair
    always_comb begin
        unique case ({mode_s, str_s})
            2'b00:   state_d = ST_PAR_HOLD;
            2'b01:   state_d = ST_PAR_OPEN;
            2'b10:   state_d = ST_SER_ARMED;
            default: state_d = ST_SER_LOCKED;
        endcase
    end

    // Outputs
    always_comb begin
        load_par = !mode_s && str_s;
        shift_en = mode_s && !str_s && sclk_rise;
        unique case (state_q)
            ST_PAR_HOLD,
            ST_SER_ARMED:  load_ser = mode_s && str_s;
            ST_PAR_OPEN,
            ST_SER_LOCKED: load_ser = 1'b0;
            default:       load_ser = 1'b0;
        endcase
    end

endmodule

// File: rtl/gwi_shift.sv
module gwi_shift #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         bit_in,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= {q[W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/gwi_gain_reg.sv
module gwi_gain_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_par,
    input  logic [W-1:0] par_word,
    input  logic         load_ser,
    input  logic [W-1:0] ser_word,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_par) begin
            q <= par_word;
        end else if (load_ser) begin
            q <= ser_word;
        end
    end

endmodule

// File: rtl/gain_word_if.sv
module gain_word_if
    import gwi_pkg::*;
#(
    parameter int WORD_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_sel,
    input  logic              strobe_in,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] gain_q
);

    localparam int BUS_W = WORD_W + 2;

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  syn_bus;
    logic              mode_s;
    logic              str_s;
    logic [WORD_W-1:0] dat_s;
    logic              sclk_rise;
    logic              load_par;
    logic              load_ser;
    logic              shift_en;
    logic [WORD_W-1:0] shift_q;

    assign raw_bus = {mode_sel, strobe_in, data_in};

    gwi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_bus),
        .q   (syn_bus)
    );

    assign mode_s = syn_bus[BUS_W-1];
    assign str_s  = syn_bus[BUS_W-2];
    assign dat_s  = syn_bus[WORD_W-1:0];

    gwi_rise u_sclk_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  (dat_s[SCLK_IDX]),
        .rise (sclk_rise)
    );

    gwi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode_s    (mode_s),
        .str_s     (str_s),
        .sclk_rise (sclk_rise),
        .load_par  (load_par),
        .load_ser  (load_ser),
        .shift_en  (shift_en)
    );

    gwi_shift #(.W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (shift_en),
        .bit_in (dat_s[SDATA_IDX]),
        .q      (shift_q)
    );

    gwi_gain_reg #(.W(WORD_W)) u_gain (
        .clk      (clk),
        .rst      (rst),
        .load_par (load_par),
        .par_word (dat_s),
        .load_ser (load_ser),
        .ser_word (shift_q),
        .q        (gain_q)
    );

endmodule

// File: rtl/gwi_checker.sv
module gwi_checker #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         mode_s,
    input logic         str_s,
    input logic [W-1:0] dat_s,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] gain_q
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (gain_q == '0 && shift_q == '0));

    // R3
    a_r3_follow: assert property (@(posedge clk) disable iff (rst)
        (!mode_s && str_s) |=> (gain_q == $past(dat_s)));

    // R4
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!mode_s && !str_s) |=> $stable(gain_q));

    // R6
    a_r6_xfer: assert property (@(posedge clk) disable iff (rst)
        (mode_s && str_s && !$past(str_s)) |=> (gain_q == $past(shift_q)));

    // R6, R2
    a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode_s && !(str_s && !$past(str_s))) |=> $stable(gain_q));

    // R5
    a_r5_shift: assert property (@(posedge clk) disable iff (rst)
        (mode_s && !str_s && dat_s[1] && !$past(dat_s[1]))
        |=> (shift_q == {$past(shift_q[W-2:0]), $past(dat_s[0])}));

    // R7, R8
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (str_s || !mode_s) |=> $stable(shift_q));

    // R9
    a_r9_collide: assert property (@(posedge clk) disable iff (rst)
        (mode_s && str_s && !$past(str_s) && dat_s[1] && !$past(dat_s[1]))
        |=> $stable(shift_q));

endmodule

bind gain_word_if gwi_checker #(.W(WORD_W)) u_gwi_checker (
    .clk     (clk),
    .rst     (rst),
    .mode_s  (mode_s),
    .str_s   (str_s),
    .dat_s   (dat_s),
    .shift_q (shift_q),
    .gain_q  (gain_q)
);

// File: tb/gain_word_if_bench.sv
`timescale 1ns/1ps
module gain_word_if_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_sel = 1'b0;
    logic       strobe_in = 1'b0;
    logic [3:0] data_in = 4'h0;
    logic [3:0] gain_q;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    gain_word_if u_gain_word_if (
        .clk       (clk),
        .rst       (rst),
        .mode_sel  (mode_sel),
        .strobe_in (strobe_in),
        .data_in   (data_in),
        .gain_q    (gain_q)
    );

    // Behavioural reference: pin history queue, index 2 = value seen now, 3 = previous
    logic [5:0] hist[$] = '{6'd0, 6'd0, 6'd0, 6'd0};
    logic [3:0] m_gain = 4'h0;
    logic [3:0] m_shift = 4'h0;

    always @(posedge clk) begin
        logic [5:0] cur;
        logic [5:0] prv;
        if (rst) begin
            hist = '{6'd0, 6'd0, 6'd0, 6'd0};
            m_gain = 4'h0;
            m_shift = 4'h0;
        end else begin
            hist.push_front({mode_sel, strobe_in, data_in});
            void'(hist.pop_back());
            cur = hist[2];
            prv = hist[3];
            if (!cur[5]) begin
                if (cur[4]) m_gain = cur[3:0];
            end else if (cur[4] && !prv[4]) begin
                m_gain = m_shift;
            end else if (!cur[4] && cur[1] && !prv[1]) begin
                m_shift = {m_shift[2:0], cur[0]};
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            total++;
            if (gain_q !== m_gain) begin
                bad++;
                $display("FAIL %s model compare got=%b exp=%b", phase, gain_q, m_gain);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        total++;
        if (gain_q !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", req, gain_q, exp);
        end
    endtask

    task automatic sclk_bit(input bit b);
        data_in[0] = b;
        data_in[1] = 1'b0;
        step(3);
        data_in[1] = 1'b1;
        step(3);
        data_in[1] = 1'b0;
        step(3);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog got=running exp=finished");
            finish_up();
        end
    end

    initial begin
        step(4);
        rst = 1'b0;
        step(1);
        check("R1 reset", 4'b0000);
        step(6);
        check("R1 idle low pins", 4'b0000);

        // R3 / R10: transparent parallel loading and latency
        phase = "R3";
        mode_sel = 1'b0;
        strobe_in = 1'b1;
        data_in = 4'h5;
        step(2);
        check("R10 not yet", 4'b0000);
        step(1);
        check("R10 at edge n+2", 4'h5);
        data_in = 4'hA;
        step(4);
        check("R3 follow", 4'hA);

        // R4: capture and hold
        phase = "R4";
        data_in = 4'h6;
        step(4);
        strobe_in = 1'b0;
        step(4);
        data_in = 4'hF;
        step(6);
        check("R4 hold", 4'h6);
        data_in = 4'h3;
        step(4);
        check("R4 hold again", 4'h6);

        // R2 / R5 / R6: serial load
        phase = "R6";
        mode_sel = 1'b1;
        step(4);
        check("R2 mode switch", 4'h6);
        sclk_bit(1'b1);
        sclk_bit(1'b0);
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        check("R6 no transfer yet", 4'h6);
        strobe_in = 1'b1;
        step(4);
        check("R5 serial word", 4'b1011);
        data_in = 4'h9;
        step(4);
        check("R2 serial pins ignored", 4'b1011);

        // R7: clock ignored while strobe high, then partial shift
        phase = "R7";
        data_in = 4'h0;
        sclk_bit(1'b0);
        sclk_bit(1'b0);
        sclk_bit(1'b0);
        sclk_bit(1'b0);
        strobe_in = 1'b0;
        step(4);
        sclk_bit(1'b0);
        sclk_bit(1'b0);
        strobe_in = 1'b1;
        step(4);
        check("R7 frozen then R5 order", 4'b1100);

        // R9: strobe rise and bit-clock rise together
        phase = "R9";
        strobe_in = 1'b0;
        data_in = 4'b0001;
        step(4);
        strobe_in = 1'b1;
        data_in[1] = 1'b1;
        step(4);
        check("R9 transfer wins", 4'b1100);
        strobe_in = 1'b0;
        step(4);
        strobe_in = 1'b1;
        step(4);
        check("R9 no shift", 4'b1100);
        data_in[1] = 1'b0;

        // R8: parallel mode does not shift
        phase = "R8";
        strobe_in = 1'b0;
        mode_sel = 1'b0;
        step(4);
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        sclk_bit(1'b1);
        check("R4 hold in R8", 4'b1100);
        mode_sel = 1'b1;
        step(4);
        strobe_in = 1'b1;
        step(4);
        check("R8 shift untouched", 4'b1100);

        // R1: reset mid-operation
        phase = "R1";
        rst = 1'b1;
        strobe_in = 1'b0;
        mode_sel = 1'b0;
        data_in = 4'h0;
        step(2);
        rst = 1'b0;
        step(1);
        check("R1 reset again", 4'b0000);
        step(4);
        finish_up();
    end

endmodule